// File: doc/BRIEF.md
# ECC Error Capture Unit

This unit sits beside a memory controller and keeps a record of error-correction events so that software can inspect them later. On any cycle the controller may flag a single-bit corrected event, a noncorrectable event, or both, and presents the access address, the 8-bit syndrome, the access attributes, the requesting master ID and the 32-bit data word of that access on shared event buses.

A configuration register turns reporting on or off for each event class. When an enabled event arrives, every detail of the access is captured in one snapshot, and a status flag for that class is set. Software reads the snapshot and status through a simple word-indexed register port and clears flags by writing ones. The snapshot registers always reflect the most recent enabled event. They are read-only, and they have no reset value.

Register word indices: 0 = configuration (bit 0 enables corrected events, bit 1 enables noncorrectable events, other bits read 0); 1 = status (bit 0 corrected flag, bit 1 noncorrectable flag, write 1 to clear); 2 = captured address; 3 = captured syndrome in bits 7:0 with bit 8 set when the captured event was noncorrectable; 4 = captured attributes in bits 3:0; 5 = captured master ID in bits 3:0; 6 = captured data word; 7 = unmapped.

Top module: `ecc_capture_unit`

## Requirements
- R1: After reset the configuration and status registers read 0 and the read data output is 0.
- R2: An event whose class is not enabled in the configuration register (bit 0 corrected, bit 1 noncorrectable) changes neither the status flags nor any captured detail.
- R3: An enabled event loads address (index 2), syndrome (index 3 bits 7:0), attributes (index 4), master ID (index 5) and data word (index 6) together in its cycle, with the data word taken unmodified from the event data bus.
- R4: An enabled corrected event sets status bit 0, and an enabled noncorrectable event sets status bit 1.
- R5: Each enabled event overwrites the snapshot left by the previous one.
- R6: Writes to indices 2 to 6 are ignored, and the snapshot changes only on an enabled event.
- R7: Writing 1 to a status bit clears it, writing 0 leaves it, and an enabled event of that class in the same cycle keeps the bit set.
- R8: When both classes are flagged and enabled in the same cycle, the snapshot records the noncorrectable event (index 3 bit 8 = 1) and both status bits are set.
- R9: Read data appears on the cycle after the read strobe and is 0 on cycles that follow no strobe. Index 7 reads as 0.
- R10: The configuration register holds only bits 1:0 of a write to index 0. It is read back with all other bits 0, and a write to it takes effect for events from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_corr_i | input | 1 | Single-bit corrected event this cycle |
| evt_unc_i | input | 1 | Noncorrectable event this cycle |
| evt_addr_i | input | 32 | Faulting access address |
| evt_syn_i | input | 8 | Error syndrome |
| evt_attr_i | input | 4 | Access attributes |
| evt_mid_i | input | 4 | Requesting master ID |
| evt_data_i | input | 32 | Data bus value of the access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the strobe |

## Verification
A wrong internal state shows up at the read port. A flag that is missed or cleared wrongly appears in the status word on the first read after the event. A snapshot that is torn or stale returns a field that does not match the last enabled event. A configuration bit that is wrong lets a disabled event through, or drops an enabled one, and that shows on the next status or detail read. The bench therefore reads a register on most cycles and checks every read against a behavioural model. A fault is seen one cycle after the first read that reaches the affected register.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SYN_W  = 8;
    localparam int ATTR_W = 4;
    localparam int MID_W  = 4;
    localparam int RIDX_W = 3;
    localparam int NCLASS = 2;
    localparam int CLS_CORR = 0;
    localparam int CLS_UNC  = 1;

    typedef enum logic [RIDX_W-1:0] {
        REG_CFG  = 3'd0,
        REG_STAT = 3'd1,
        REG_ADDR = 3'd2,
        REG_SYN  = 3'd3,
        REG_ATTR = 3'd4,
        REG_MID  = 3'd5,
        REG_DATA = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SYN_W-1:0]  syn;
        logic              kind;
        logic [ATTR_W-1:0] attr;
        logic [MID_W-1:0]  mid;
        logic [DATA_W-1:0] data;
    } snap_t;

    typedef struct packed {
        logic [NCLASS-1:0] cfg;
        logic [NCLASS-1:0] stat;
    } ctrl_t;
endpackage

// File: rtl/ecc_evt_qual.sv
module ecc_evt_qual
    import ecc_cap_pkg::*;
(
    input  logic [NCLASS-1:0] evt_i,
    input  logic [NCLASS-1:0] cfg_i,
    output logic [NCLASS-1:0] set_o,
    output logic              cap_o,
    output logic              kind_o
);
    for (genvar c = 0; c < NCLASS; c++) begin : g_cls
        assign set_o[c] = evt_i[c] & cfg_i[c];
    end

    assign cap_o  = |set_o;
    // noncorrectable class owns the snapshot when both qualify
    assign kind_o = set_o[CLS_UNC];
endmodule

// File: rtl/ecc_ctrl_regs.sv
module ecc_ctrl_regs
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [RIDX_W-1:0] idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NCLASS-1:0] set_i,
    output logic [NCLASS-1:0] cfg_o,
    output logic [NCLASS-1:0] stat_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic [NCLASS-1:0] clr;

    always_comb begin
        ctrl_d = ctrl_q;
        clr    = '0;
        if (wr_i && idx_i == REG_CFG) begin
            ctrl_d.cfg = wdata_i[NCLASS-1:0];
        end
        if (wr_i && idx_i == REG_STAT) begin
            clr = wdata_i[NCLASS-1:0];
        end
        ctrl_d.stat = (ctrl_q.stat & ~clr) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign cfg_o  = ctrl_q.cfg;
    assign stat_o = ctrl_q.stat;

    for (genvar c = 0; c < NCLASS; c++) begin : g_chk
        AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_o[c]) |-> $past(set_i[c])); // R4
        AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[c] |=> stat_o[c]); // R7
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && idx_i == REG_STAT && wdata_i[c] && !set_i[c]) |=> !stat_o[c]); // R7
    end
endmodule

// File: rtl/ecc_snap_regs.sv
module ecc_snap_regs
    import ecc_cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cap_i,
    input  snap_t snap_i,
    output snap_t snap_o
);
    snap_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (cap_i) snap_d = snap_i;
    end

    // detail storage carries no reset
    always_ff @(posedge clk) begin
        snap_q <= snap_d;
    end

    assign snap_o = snap_q;

    AST_SNAPSHOT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (snap_o == $past(snap_i))); // R3
    AST_SNAPSHOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(snap_o)); // R6
endmodule

// File: rtl/ecc_read_port.sv
module ecc_read_port
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [RIDX_W-1:0] idx_i,
    input  logic [NCLASS-1:0] cfg_i,
    input  logic [NCLASS-1:0] stat_i,
    input  snap_t             snap_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_CLS = DATA_W - NCLASS;
    localparam int PAD_SYN = DATA_W - SYN_W - 1;
    localparam int PAD_ATR = DATA_W - ATTR_W;
    localparam int PAD_MID = DATA_W - MID_W;

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (rd_i) begin
            case (idx_i)
                REG_CFG:  rdata_d = {{PAD_CLS{1'b0}}, cfg_i};
                REG_STAT: rdata_d = {{PAD_CLS{1'b0}}, stat_i};
                REG_ADDR: rdata_d = DATA_W'(snap_i.addr);
                REG_SYN:  rdata_d = {{PAD_SYN{1'b0}}, snap_i.kind, snap_i.syn};
                REG_ATTR: rdata_d = {{PAD_ATR{1'b0}}, snap_i.attr};
                REG_MID:  rdata_d = {{PAD_MID{1'b0}}, snap_i.mid};
                REG_DATA: rdata_d = snap_i.data;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (rdata_o == '0)); // R9
endmodule

// File: rtl/ecc_capture_unit.sv
module ecc_capture_unit
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_corr_i,
    input  logic              evt_unc_i,
    input  logic [ADDR_W-1:0] evt_addr_i,
    input  logic [SYN_W-1:0]  evt_syn_i,
    input  logic [ATTR_W-1:0] evt_attr_i,
    input  logic [MID_W-1:0]  evt_mid_i,
    input  logic [DATA_W-1:0] evt_data_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [RIDX_W-1:0] reg_idx_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o
);
    logic [NCLASS-1:0] evt, cfg, stat, set;
    logic              cap, kind;
    snap_t             snap_in, snap;

    assign evt[CLS_CORR] = evt_corr_i;
    assign evt[CLS_UNC]  = evt_unc_i;

    ecc_evt_qual u_qual (
        .evt_i  (evt),
        .cfg_i  (cfg),
        .set_o  (set),
        .cap_o  (cap),
        .kind_o (kind)
    );

    ecc_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .idx_i   (reg_idx_i),
        .wdata_i (reg_wdata_i),
        .set_i   (set),
        .cfg_o   (cfg),
        .stat_o  (stat)
    );

    always_comb begin
        snap_in      = '0;
        snap_in.addr = evt_addr_i;
        snap_in.syn  = evt_syn_i;
        snap_in.kind = kind;
        snap_in.attr = evt_attr_i;
        snap_in.mid  = evt_mid_i;
        snap_in.data = evt_data_i;
    end

    ecc_snap_regs u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .snap_i (snap_in),
        .snap_o (snap)
    );

    ecc_read_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (reg_rd_i),
        .idx_i   (reg_idx_i),
        .cfg_i   (cfg),
        .stat_i  (stat),
        .snap_i  (snap),
        .rdata_o (reg_rdata_o)
    );

    AST_UNC_OWNS_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_unc_i && evt_corr_i && cfg == 2'b11) |=> (snap.kind && stat == 2'b11)); // R8
    AST_DISABLED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & cfg) == '0) |=> $stable(snap)); // R2
endmodule

// File: tb/ecc_capture_unit_tb.sv
module ecc_capture_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_corr_i = 0, evt_unc_i = 0;
    logic [31:0] evt_addr_i = 0, evt_data_i = 0, reg_wdata_i = 0;
    logic [7:0]  evt_syn_i = 0;
    logic [3:0]  evt_attr_i = 0, evt_mid_i = 0;
    logic        reg_wr_i = 0, reg_rd_i = 0;
    logic [2:0]  reg_idx_i = 0;
    logic [31:0] reg_rdata_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural model state
    bit [1:0]  m_cfg = 0, m_st = 0;
    bit        m_valid = 0, m_kind = 0;
    bit [31:0] m_addr, m_data;
    bit [7:0]  m_syn;
    bit [3:0]  m_attr, m_mid;

    always #4 clk = ~clk;

    ecc_capture_unit u_dut (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit c, input bit u, input logic [31:0] a, input logic [7:0] s,
                       input logic [3:0] at, input logic [3:0] mi, input logic [31:0] d,
                       input bit w, input bit r, input logic [2:0] ix,
                       input logic [31:0] wd, input string tag);
        logic [31:0] exp;
        bit known;
        bit [1:0] set, clr;
        evt_corr_i = c; evt_unc_i = u; evt_addr_i = a; evt_syn_i = s;
        evt_attr_i = at; evt_mid_i = mi; evt_data_i = d;
        reg_wr_i = w; reg_rd_i = r; reg_idx_i = ix; reg_wdata_i = wd;
        exp = 0; known = 1;
        if (r) begin
            case (ix)
                3'd0: exp = {30'd0, m_cfg};
                3'd1: exp = {30'd0, m_st};
                3'd2: begin exp = m_addr; known = m_valid; end
                3'd3: begin exp = {23'd0, m_kind, m_syn}; known = m_valid; end
                3'd4: begin exp = {28'd0, m_attr}; known = m_valid; end
                3'd5: begin exp = {28'd0, m_mid}; known = m_valid; end
                3'd6: begin exp = m_data; known = m_valid; end
                default: exp = 0;
            endcase
        end
        set = {u & m_cfg[1], c & m_cfg[0]};
        clr = (w && ix == 3'd1) ? wd[1:0] : 2'b00;
        if (w && ix == 3'd0) m_cfg = wd[1:0];
        m_st = (m_st & ~clr) | set;
        if (set != 0) begin
            m_valid = 1; m_kind = set[1]; m_addr = a; m_syn = s;
            m_attr = at; m_mid = mi; m_data = d;
        end
        @(negedge clk);
        if (known) check(reg_rdata_o, exp, tag);
    endtask

    task automatic rd(input logic [2:0] ix, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, ix, 0, tag);
    endtask

    task automatic wr(input logic [2:0] ix, input logic [31:0] wd, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, ix, wd, tag);
    endtask

    task automatic ev(input bit c, input bit u, input logic [31:0] a, input logic [7:0] s,
                      input logic [3:0] at, input logic [3:0] mi, input logic [31:0] d,
                      input string tag);
        cyc(c, u, a, s, at, mi, d, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(reg_rdata_o, 0, "R1 reset rdata");
        rd(3'd0, "R1 cfg after reset");
        rd(3'd1, "R1 status after reset");

        // disabled classes
        ev(1, 1, 32'hDEAD_0000, 8'h11, 4'h1, 4'h2, 32'h1234_5678, "R2");
        rd(3'd1, "R2 status unchanged while disabled");

        // configuration
        wr(3'd0, 32'hFFFF_FFFF, "R10");
        rd(3'd0, "R10 cfg holds two bits");

        // corrected capture
        ev(1, 0, 32'h8000_1004, 8'h5A, 4'hA, 4'h3, 32'hCAFE_F00D, "R3");
        rd(3'd2, "R3 address");
        rd(3'd3, "R3 syndrome");
        rd(3'd4, "R3 attributes");
        rd(3'd5, "R3 master id");
        rd(3'd6, "R3 data word");
        rd(3'd1, "R4 corrected flag");

        // overwrite by noncorrectable
        ev(0, 1, 32'h0000_2220, 8'hC3, 4'h5, 4'hF, 32'h0BAD_BEEF, "R5");
        rd(3'd2, "R5 address overwritten");
        rd(3'd3, "R5 syndrome and kind");
        rd(3'd1, "R4 both flags");

        // writes to detail registers
        wr(3'd2, 32'h1111_1111, "R6");
        wr(3'd6, 32'h2222_2222, "R6");
        rd(3'd2, "R6 address unchanged");
        rd(3'd6, "R6 data unchanged");

        // clear versus event
        cyc(1, 0, 32'h44, 8'h01, 4'h0, 4'h1, 32'h55, 1, 0, 3'd1, 32'h1, "R7");
        rd(3'd1, "R7 event wins over clear");
        wr(3'd1, 32'h1, "R7");
        rd(3'd1, "R7 corrected flag cleared");
        wr(3'd1, 32'h0, "R7");
        rd(3'd1, "R7 zero write leaves flag");
        wr(3'd1, 32'h2, "R7");
        rd(3'd1, "R7 all clear");

        // simultaneous classes
        ev(1, 1, 32'h7777_0000, 8'h9E, 4'h7, 4'h8, 32'hA5A5_A5A5, "R8");
        rd(3'd3, "R8 noncorrectable kind recorded");
        rd(3'd1, "R8 both flags");

        // one class disabled
        wr(3'd1, 32'h3, "R2");
        wr(3'd0, 32'h1, "R2");
        ev(0, 1, 32'h9999_9999, 8'hFF, 4'hF, 4'hF, 32'h0, "R2");
        rd(3'd1, "R2 disabled class sets no flag");
        rd(3'd2, "R2 disabled class leaves address");

        // config write takes effect next cycle
        cyc(0, 1, 32'h3333, 8'h33, 4'h3, 4'h3, 32'h3, 1, 0, 3'd0, 32'h2, "R10");
        rd(3'd1, "R10 old config gates same-cycle event");

        // read port details
        rd(3'd7, "R9 unmapped reads zero");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd0, 0, "R9");
        check(reg_rdata_o, 0, "R9 no strobe returns zero");

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 4) == 0, ($urandom % 5) == 0, $urandom, 8'($urandom),
                4'($urandom), 4'($urandom), $urandom,
                ($urandom % 6) == 0, ($urandom % 4) != 0, 3'($urandom),
                $urandom, "R5 random");
        end
        finish_run();
    end
endmodule